// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block sits beside a small CPU core and manages its deepest sleep. When the core signals a stop request, the sequencer issues one-cycle register-update strobes. It then gates clocks according to a static depth strap. With the strap low, the oscillator is shut off, and with it the watchdog. With the strap high, only the CPU and bus clock is held, while the oscillator, the timers and the watchdog keep running.

While asleep, the sequencer watches the wake sources allowed in the current depth. After a wake it holds the CPU clock off for an oscillator-settling interval, whose length a second strap picks. In full-stop this interval counts from zero. In halt it starts from the sampled value of the free-running timer, so it can be shorter than nominal but is never longer. When the interval ends, a one-cycle indication reports whether the wake came from an interrupt or from a reset.

Top module: `sleep_seq`

## Requirements
- R1: After `rst_n` deasserts, the block is running: `cpu_clk_en`, `osc_en` and `wdt_clk_en` are 1, and every strobe and wake indication is 0.
- R2: When `stop_req` is high while the block is running, `clr_imask` and `set_irqe` are 1 in that same cycle only. In that cycle `cpu_clk_en` is still 1. This holds in both depths.
- R3: In that same cycle, with `mode_halt`=0, `clr_tof`, `clr_rtif`, `clr_tofe` and `clr_rtie` are also 1. With `mode_halt`=1 they stay 0.
- R4: From the cycle after a full-stop entry, `osc_en`, `wdt_clk_en` and `cpu_clk_en` are all 0 until a wake is taken.
- R5: From the cycle after a halt entry, `cpu_clk_en` is 0 while `osc_en` and `wdt_clk_en` stay 1.
- R6: In full-stop, only `irq_wake`, `ext_rst` or `lvr_rst` ends the sleep. `tmr_wake` leaves `osc_en` at 0.
- R7: In halt, any of `tmr_wake`, `irq_wake`, `ext_rst` or `lvr_rst` ends the sleep.
- R8: The terminal count T is 224 when `dly_long`=0 and 4064 when `dly_long`=1. After a full-stop wake, the counter starts at 0. `cpu_clk_en` stays 0 for exactly T+1 cycles after the wake edge, while `osc_en` and `wdt_clk_en` are 1.
- R9: After a halt wake, the counter starts at the value of `tmr_cnt` sampled at the wake edge. If that value is at or above T, T is used instead. `cpu_clk_en` stays 0 for T−start+1 cycles, which is never more than T+1.
- R10: In the last settling cycle, exactly one of `wake_int` or `wake_rst` is 1. A reset source wins over an interrupt in the wake cycle, and it also wins if it arrives at any point during settling.
- R11: A `stop_req` while asleep or settling is ignored. No strobe fires, and the settling length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| mode_halt | input | 1 | Depth strap: 0 full-stop, 1 halt |
| dly_long | input | 1 | Settling strap: 0 short, 1 long |
| stop_req | input | 1 | Stop instruction executed |
| irq_wake | input | 1 | External interrupt request |
| tmr_wake | input | 1 | Timer interrupt request |
| ext_rst | input | 1 | External reset pin event |
| lvr_rst | input | 1 | Low-voltage reset event |
| tmr_cnt | input | CW | Free-running timer value |
| osc_en | output | 1 | Oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| cpu_clk_en | output | 1 | CPU and bus clock enable |
| clr_imask | output | 1 | Clear CPU interrupt-mask bit |
| set_irqe | output | 1 | Set external-interrupt enable bit |
| clr_tof | output | 1 | Clear timer overflow flag |
| clr_rtif | output | 1 | Clear real-time interrupt flag |
| clr_tofe | output | 1 | Clear timer overflow enable |
| clr_rtie | output | 1 | Clear real-time interrupt enable |
| wake_int | output | 1 | Exit caused by an interrupt |
| wake_rst | output | 1 | Exit caused by a reset |

## Verification
The strobes and wake indications are combinational. They are due in the same cycle as the input or count that causes them. The clock enables change one edge after the stop request or wake. The settling lengths run T−start+1 cycles from the wake edge. The bench drives inputs on the falling edge and samples outputs one nanosecond later. It advances its cycle model only on the rising edge. Each output is therefore compared in the cycle where it is due, and the settling length is counted in whole cycles.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int CW        = 12,
  parameter int SHORT_DLY = 224,
  parameter int LONG_DLY  = 4064
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_halt,
  input  logic          dly_long,
  input  logic          stop_req,
  input  logic          irq_wake,
  input  logic          tmr_wake,
  input  logic          ext_rst,
  input  logic          lvr_rst,
  input  logic [CW-1:0] tmr_cnt,
  output logic          osc_en,
  output logic          wdt_clk_en,
  output logic          cpu_clk_en,
  output logic          clr_imask,
  output logic          set_irqe,
  output logic          clr_tof,
  output logic          clr_rtif,
  output logic          clr_tofe,
  output logic          clr_rtie,
  output logic          wake_int,
  output logic          wake_rst
);
  typedef enum logic [1:0] {RUN, SLEEP_STOP, SLEEP_HALT, STABILISE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          cause_rst;

  logic [CW-1:0] term;
  logic          rst_ev, accept, last;

  assign term   = dly_long ? CW'(LONG_DLY) : CW'(SHORT_DLY);
  assign rst_ev = ext_rst | lvr_rst;
  assign accept = (state == RUN) & stop_req;
  assign last   = (state == STABILISE) & (cnt == term);

  assign cpu_clk_en = (state == RUN);
  assign osc_en     = (state != SLEEP_STOP);
  assign wdt_clk_en = osc_en;

  assign clr_imask = accept;
  assign set_irqe  = accept;
  assign clr_tof   = accept & ~mode_halt;
  assign clr_rtif  = accept & ~mode_halt;
  assign clr_tofe  = accept & ~mode_halt;
  assign clr_rtie  = accept & ~mode_halt;

  assign wake_rst = last & (cause_rst | rst_ev);
  assign wake_int = last & ~(cause_rst | rst_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RUN;
      cnt       <= '0;
      cause_rst <= 1'b0;
    end else begin
      case (state)
        RUN: if (stop_req) state <= mode_halt ? SLEEP_HALT : SLEEP_STOP;
        SLEEP_STOP:
          if (rst_ev | irq_wake) begin
            state     <= STABILISE;
            cnt       <= '0;
            cause_rst <= rst_ev;
          end
        SLEEP_HALT:
          if (rst_ev | irq_wake | tmr_wake) begin
            state     <= STABILISE;
            cnt       <= (tmr_cnt >= term) ? term : tmr_cnt;
            cause_rst <= rst_ev;
          end
        STABILISE: begin
          if (rst_ev) cause_rst <= 1'b1;
          if (cnt == term) state <= RUN;
          else cnt <= cnt + 1'b1;
        end
        default: state <= RUN;
      endcase
    end
  end

  logic [CW:0] stab_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stab_n <= '0;
    else if (state == STABILISE) stab_n <= stab_n + 1'b1;
    else stab_n <= '0;
  end

  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) set_irqe |=> !set_irqe); // R2
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stop_req && !mode_halt) |=> (!osc_en && !wdt_clk_en && !cpu_clk_en)); // R4
  AST_HALT_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stop_req && mode_halt) |=> (osc_en && wdt_clk_en && !cpu_clk_en)); // R5
  AST_TMR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !irq_wake && !ext_rst && !lvr_rst) |=> !osc_en); // R6
  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == STABILISE) |-> (stab_n <= {1'b0, term})); // R9
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_int, wake_rst})); // R10
endmodule

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode_halt, dly_long, stop_req, irq_wake, tmr_wake, ext_rst, lvr_rst;
  logic [11:0] tmr_cnt;
  logic osc_en, wdt_clk_en, cpu_clk_en, clr_imask, set_irqe;
  logic clr_tof, clr_rtif, clr_tofe, clr_rtie, wake_int, wake_rst;

  sleep_seq u_sleep_seq (
    .clk(clk), .rst_n(rst_n), .mode_halt(mode_halt), .dly_long(dly_long),
    .stop_req(stop_req), .irq_wake(irq_wake), .tmr_wake(tmr_wake),
    .ext_rst(ext_rst), .lvr_rst(lvr_rst), .tmr_cnt(tmr_cnt),
    .osc_en(osc_en), .wdt_clk_en(wdt_clk_en), .cpu_clk_en(cpu_clk_en),
    .clr_imask(clr_imask), .set_irqe(set_irqe), .clr_tof(clr_tof),
    .clr_rtif(clr_rtif), .clr_tofe(clr_tofe), .clr_rtie(clr_rtie),
    .wake_int(wake_int), .wake_rst(wake_rst));

  int checks = 0, failures = 0;
  int m_state = 0, m_left = 0;
  bit m_rc = 0;
  bit s_cpu, s_wrst, s_wint, s_strb;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic sr, iw, tw, er, lr, input logic [11:0] tc);
    int t, st;
    bit acc, lst, rs;
    stop_req = sr; irq_wake = iw; tmr_wake = tw; ext_rst = er; lvr_rst = lr; tmr_cnt = tc;
    #1;
    t   = dly_long ? 4064 : 224;
    acc = (m_state == 0) && sr;
    lst = (m_state == 3) && (m_left == 0);
    rs  = m_rc || er || lr;
    chk("R8", "cpu_clk_en", cpu_clk_en, m_state == 0);
    chk("R4", "osc_en", osc_en, m_state != 1);
    chk("R5", "wdt_clk_en", wdt_clk_en, m_state != 1);
    chk("R2", "clr_imask", clr_imask, acc);
    chk("R2", "set_irqe", set_irqe, acc);
    chk("R3", "timer clears", {clr_tof, clr_rtif, clr_tofe, clr_rtie},
        (acc && !mode_halt) ? 15 : 0);
    chk("R10", "wake_rst", wake_rst, lst && rs);
    chk("R10", "wake_int", wake_int, lst && !rs);
    s_cpu = cpu_clk_en; s_strb = set_irqe | clr_imask;
    if (wake_rst) s_wrst = 1;
    if (wake_int) s_wint = 1;
    @(posedge clk);
    case (m_state)
      0: if (sr) m_state = mode_halt ? 2 : 1;
      1: if (iw || er || lr) begin m_state = 3; m_left = t; m_rc = er || lr; end
      2: if (iw || tw || er || lr) begin
           st = (int'(tc) >= t) ? t : int'(tc);
           m_state = 3; m_left = t - st; m_rc = er || lr;
         end
      default: begin
        if (er || lr) m_rc = 1;
        if (m_left == 0) m_state = 0; else m_left--;
      end
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 12'd0);
  endtask

  task automatic settle(output int n);
    n = 0;
    s_wrst = 0; s_wint = 0;
    do begin
      cyc(0, 0, 0, 0, 0, 12'd0);
      if (!s_cpu) n++;
    end while (!s_cpu && n < 5000);
  endtask

  int n;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; mode_halt = 0; dly_long = 0; stop_req = 0; irq_wake = 0;
    tmr_wake = 0; ext_rst = 0; lvr_rst = 0; tmr_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset enables", {cpu_clk_en, osc_en, wdt_clk_en}, 7);
    chk("R1", "reset strobes", {clr_imask, set_irqe, clr_tof, clr_rtif, clr_tofe, clr_rtie,
        wake_int, wake_rst}, 0);
    @(negedge clk);

    // full-stop, short settle, IRQ wake
    idle(3);
    cyc(1, 0, 0, 0, 0, 0);
    idle(4);
    cyc(0, 0, 1, 0, 0, 12'd50);
    idle(1);
    chk("R6", "timer wake ignored in full-stop", osc_en, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R11", "stop while asleep no strobe", s_strb, 0);
    cyc(0, 1, 0, 0, 0, 0);
    settle(n);
    chk("R8", "full-stop short settle cycles", n, 225);
    chk("R10", "irq wake reports interrupt", {s_wint, s_wrst}, 2);

    // full-stop, long settle, reset and IRQ together
    dly_long = 1;
    cyc(1, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 1, 0, 1, 0, 0);
    settle(n);
    chk("R8", "full-stop long settle cycles", n, 4065);
    chk("R10", "reset wins over irq", {s_wint, s_wrst}, 1);

    // halt, short settle, timer wake from tmr_cnt=100
    dly_long = 0; mode_halt = 1;
    cyc(1, 0, 0, 0, 0, 0);
    idle(3);
    cyc(0, 0, 1, 0, 0, 12'd100);
    chk("R7", "timer wakes halt", 1, 1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R11", "stop while settling no strobe", s_strb, 0);
    settle(n);
    chk("R9", "halt settle from timer value", n + 1, 125);
    chk("R10", "timer wake reports interrupt", {s_wint, s_wrst}, 2);

    // halt, long settle, timer above terminal clamps
    dly_long = 1;
    cyc(1, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 1, 0, 0, 0, 12'd4090);
    settle(n);
    chk("R9", "halt settle clamped", n, 1);

    // halt, short, low-voltage wake from 0
    dly_long = 0;
    cyc(1, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1, 12'd0);
    settle(n);
    chk("R7", "lvr wakes halt full settle", n, 225);
    chk("R10", "lvr wake reports reset", {s_wint, s_wrst}, 1);

    // full-stop, IRQ wake, reset arriving mid-settle
    mode_halt = 0;
    cyc(1, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 1, 0, 0, 0, 0);
    idle(10);
    cyc(0, 0, 0, 0, 1, 0);
    settle(n);
    chk("R10", "reset during settle wins", {s_wint, s_wrst}, 1);
    chk("R8", "remaining settle cycles", n, 225 - 11);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule